// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a stereo serial audio stream as a slave. The frame clock and the bit clock both come from outside. The block runs directly on the bit clock, so it produces no clocks and recovers none. Up to three serial data lanes share one framing. Each lane yields a left and a right two's-complement sample, presented as a 24-bit parallel word. A single strobe marks each completed stereo frame, and it covers all lanes together.

A 3-bit framing code selects one of five framings:
- right-justified words of 16, 20 or 24 bits;
- a 24-bit left-justified word;
- the common one-bit-delayed I2S framing.

The block latches the code only while reset is held. A framing shorter than 24 bits is placed in the top of the output word, and the bits below it are zero. Codes that name no framing raise an error flag and force the samples to zero.

Top module: `serial_audio_rx`

## Requirements
- R1: The framing code on `fmt_sel` is captured only while `rst_n` is low. Changing it after reset is released has no effect on how data is received.
- R2: Each data lane is sampled on the rising edge of `bclk`, most significant bit first. Two's-complement words pass through with their sign bit intact.
- R3: Codes 0, 1 and 4 select right-justified words of 16, 20 and 24 bits. The word's last bit sits on the final `bclk` cycle of each half-frame. Bits before the word are ignored. The word appears in bits [23:24-N] of the output, and the lower bits are zero.
- R4: Code 2 selects a 24-bit left-justified word. The first bit arrives on the first `bclk` cycle in which `lrclk` shows its new level. Bits after the 24th are ignored.
- R5: Code 3 selects the I2S framing. The first bit arrives one `bclk` cycle after the `lrclk` change, and the left sample is carried while `lrclk` is low.
- R6: For codes 0, 1, 2 and 4, the left sample is carried while `lrclk` is high and the right sample while it is low.
- R7: `frame_valid` is a pulse lasting one cycle. It is raised when a right half-frame ends after a complete left half-frame, and both outputs change in that same cycle and then hold. The partial half-frame seen just after reset never produces a pulse, so a run of N full frames gives exactly N pulses.
- R8: With 32 `bclk` cycles per frame, code 0 delivers the full 16-bit word. Code 3 delivers the top 16 bits, with the lower 8 output bits zero.
- R9: All three lanes use the same framing, and each lane delivers its own independent samples.
- R10: Codes 5, 6 and 7 raise `fmt_err` and force every sample output to zero. The strobe still marks each frame.
- R11: While `rst_n` is low, the sample outputs are zero and `frame_valid` stays low, whatever the serial inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; the block's only clock |
| rst_n | input | 1 | Synchronous active-low reset; the framing code is captured while it is low |
| fmt_sel | input | 3 | Framing code |
| lrclk | input | 1 | Frame (channel select) clock |
| sdata | input | LANES | Serial data, one bit per lane |
| left_data | output | LANES*SAMPLE_W | Left samples; lane k occupies bits [k*SAMPLE_W +: SAMPLE_W] |
| right_data | output | LANES*SAMPLE_W | Right samples, packed like `left_data` |
| frame_valid | output | 1 | One-cycle strobe per completed stereo frame |
| fmt_err | output | 1 | High while the latched framing code is reserved |

## Verification
The bench builds the block with its default parameters: 24-bit samples and three lanes. This means every lane and the full output word, including its zero padding, are observed at the ports. The bench drives frames of both 64 and 32 bit clocks. The short frame exercises the I2S case in which the last captured bit lands in the next half-frame. The long frame exercises the right-justified cases in which leading filler bits, driven as ones, must be discarded.

// File: rtl/srx_pkg.sv
package srx_pkg;

    // Framing codes; their numeric values are fixed by the control interface
    localparam logic [2:0] FMT_RJ16  = 3'd0;
    localparam logic [2:0] FMT_RJ20  = 3'd1;
    localparam logic [2:0] FMT_LJ24  = 3'd2;
    localparam logic [2:0] FMT_I2S   = 3'd3;
    localparam logic [2:0] FMT_RJ24  = 3'd4;

    function automatic logic fmt_reserved(input logic [2:0] f);
        return f > FMT_RJ24;
    endfunction

    // Word length carried by a right-justified framing
    function automatic int rj_bits(input logic [2:0] f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer #(
    parameter int SAMPLE_W = 24,
    parameter int CW       = $clog2(SAMPLE_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lrclk_i,
    input  logic          i2s_i,
    output logic          bound_o,
    output logic          half_end_o,
    output logic          end_left_o,
    output logic [CW-1:0] pos_o
);

    typedef struct packed {
        logic          ws1;
        logic          ws2;
        logic          armed;
        logic [CW-1:0] pos;
    } fr_t;

    fr_t s_q, s_d;
    logic cur_w, prev_w;

    always_comb begin
        // I2S is handled as a justified framing on a frame clock delayed by one bit
        cur_w  = i2s_i ? s_q.ws1 : lrclk_i;
        prev_w = i2s_i ? s_q.ws2 : s_q.ws1;
        bound_o = cur_w ^ prev_w;

        s_d       = s_q;
        s_d.ws1   = lrclk_i;
        s_d.ws2   = s_q.ws1;
        s_d.armed = s_q.armed | bound_o;
        if (bound_o)
            s_d.pos = CW'(1);
        else if (s_q.pos < CW'(SAMPLE_W))
            s_d.pos = s_q.pos + CW'(1);

        if (!rst_n) begin
            s_d.armed = 1'b0;
            s_d.pos   = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign half_end_o = bound_o & s_q.armed;
    assign end_left_o = prev_w ^ i2s_i;
    assign pos_o      = bound_o ? '0 : s_q.pos;

    // Bit position inside a half-frame never runs past the word (R4)
    p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos <= CW'(SAMPLE_W));

endmodule

// File: rtl/srx_lane.sv
module srx_lane #(
    parameter int SAMPLE_W = 24,
    parameter int CW       = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd_i,
    input  logic                bound_i,
    input  logic [CW-1:0]       pos_i,
    input  logic                left_mode_i,
    input  logic [CW-1:0]       shift_i,
    output logic [SAMPLE_W-1:0] word_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] acc;
        logic [SAMPLE_W-1:0] sh;
    } ln_t;

    ln_t s_q, s_d;
    logic [CW-1:0] idx_w;

    always_comb begin
        s_d    = s_q;
        idx_w  = CW'(SAMPLE_W - 1) - pos_i;
        // Trailing window for right-justified words
        s_d.sh = {s_q.sh[SAMPLE_W-2:0], sd_i};
        // Indexed fill for left-justified words, cleared at each half-frame start
        if (bound_i) begin
            s_d.acc               = '0;
            s_d.acc[SAMPLE_W-1]   = sd_i;
        end else if (pos_i < CW'(SAMPLE_W)) begin
            s_d.acc[idx_w] = sd_i;
        end
        if (!rst_n) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign word_o = left_mode_i ? s_q.acc : (s_q.sh << shift_i);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import srx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int LANES    = 3
) (
    input  logic                      bclk,
    input  logic                      rst_n,
    input  logic [2:0]                fmt_sel,
    input  logic                      lrclk,
    input  logic [LANES-1:0]          sdata,
    output logic [LANES*SAMPLE_W-1:0] left_data,
    output logic [LANES*SAMPLE_W-1:0] right_data,
    output logic                      frame_valid,
    output logic                      fmt_err
);

    localparam int CW = $clog2(SAMPLE_W + 1);
    localparam int LW = LANES * SAMPLE_W;

    typedef struct packed {
        logic [2:0]    fmt;
        logic [LW-1:0] hold;
        logic          have_left;
        logic [LW-1:0] out_l;
        logic [LW-1:0] out_r;
        logic          valid;
    } top_t;

    top_t s_q, s_d;

    logic          bound_w, half_end_w, end_left_w;
    logic [CW-1:0] pos_w;
    logic [LW-1:0] words_w, wsel_w;
    logic          i2s_w, left_mode_w, rsv_w;
    logic [CW-1:0] shift_w;

    assign i2s_w       = (s_q.fmt == FMT_I2S);
    assign left_mode_w = i2s_w || (s_q.fmt == FMT_LJ24);
    assign rsv_w       = fmt_reserved(s_q.fmt);
    assign shift_w     = CW'(SAMPLE_W - rj_bits(s_q.fmt));

    srx_framer #(.SAMPLE_W(SAMPLE_W), .CW(CW)) u_framer (
        .clk        (bclk),
        .rst_n      (rst_n),
        .lrclk_i    (lrclk),
        .i2s_i      (i2s_w),
        .bound_o    (bound_w),
        .half_end_o (half_end_w),
        .end_left_o (end_left_w),
        .pos_o      (pos_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        srx_lane #(.SAMPLE_W(SAMPLE_W), .CW(CW)) u_lane (
            .clk         (bclk),
            .rst_n       (rst_n),
            .sd_i        (sdata[g]),
            .bound_i     (bound_w),
            .pos_i       (pos_w),
            .left_mode_i (left_mode_w),
            .shift_i     (shift_w),
            .word_o      (words_w[g*SAMPLE_W +: SAMPLE_W])
        );

        // Short right-justified words keep their padding zero (R3)
        p_rj16_pad_r3: assert property (@(posedge bclk) disable iff (!rst_n)
            (s_q.fmt == FMT_RJ16) |->
                (left_data[g*SAMPLE_W +: SAMPLE_W-16] == '0 &&
                 right_data[g*SAMPLE_W +: SAMPLE_W-16] == '0));
    end

    assign wsel_w = rsv_w ? '0 : words_w;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (half_end_w) begin
            if (end_left_w) begin
                s_d.hold      = wsel_w;
                s_d.have_left = 1'b1;
            end else if (s_q.have_left) begin
                s_d.out_l     = s_q.hold;
                s_d.out_r     = wsel_w;
                s_d.valid     = 1'b1;
                s_d.have_left = 1'b0;
            end
        end
        if (!rst_n) begin
            s_d     = '0;
            s_d.fmt = fmt_sel;
        end
    end

    always_ff @(posedge bclk) begin
        s_q <= s_d;
    end

    assign left_data   = s_q.out_l;
    assign right_data  = s_q.out_r;
    assign frame_valid = s_q.valid;
    assign fmt_err     = rsv_w;

    // Framing code frozen once out of reset (R1)
    p_fmt_hold_r1: assert property (@(posedge bclk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(s_q.fmt));

    // Frame strobe lasts a single cycle (R7)
    p_strobe_pulse_r7: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // Reserved code yields only zero samples (R10)
    p_reserved_zero_r10: assert property (@(posedge bclk) disable iff (!rst_n)
        fmt_err |-> (left_data == '0 && right_data == '0));

endmodule

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;

    localparam int W  = 24;
    localparam int NL = 3;

    logic            bclk = 1'b0;
    logic            rst_n;
    logic [2:0]      fmt_sel;
    logic            lrclk;
    logic [NL-1:0]   sdata;
    logic [NL*W-1:0] left_data, right_data;
    logic            frame_valid, fmt_err;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int cyc    = 0;

    logic [23:0] lv [0:2];
    logic [23:0] rv [0:2];
    logic [2:0]  bit_arr [0:511];
    logic        ws_arr  [0:511];

    serial_audio_rx #(.SAMPLE_W(W), .LANES(NL)) u0 (
        .bclk(bclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .lrclk(lrclk),
        .sdata(sdata), .left_data(left_data), .right_data(right_data),
        .frame_valid(frame_valid), .fmt_err(fmt_err)
    );

    always #10 bclk = ~bclk;

    always @(negedge bclk) begin
        if (frame_valid) vcount++;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_val(input string req, input string what,
                             input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] top_bits(input logic [23:0] v, input int n);
        return v & ~(24'hFFFFFF >> n);
    endfunction

    function automatic logic [71:0] pack3(input logic [23:0] a, input logic [23:0] b,
                                          input logic [23:0] c);
        return {c, b, a};
    endfunction

    task automatic set_vals(input logic [23:0] l0, input logic [23:0] l1, input logic [23:0] l2,
                            input logic [23:0] r0, input logic [23:0] r1, input logic [23:0] r2);
        lv[0] = l0; lv[1] = l1; lv[2] = l2;
        rv[0] = r0; rv[1] = r1; rv[2] = r2;
    endtask

    function automatic logic idle_level(input logic [2:0] f);
        return (f == 3'd3);  // right-half level
    endfunction

    task automatic do_reset(input logic [2:0] f, input logic idle);
        rst_n   = 1'b0;
        fmt_sel = f;
        lrclk   = idle;
        sdata   = '0;
        repeat (4) @(negedge bclk);
        rst_n = 1'b1;
    endtask

    // Build and drive nf frames of h bit clocks per half in framing sf
    task automatic play(input logic [2:0] sf, input int h, input int nf);
        bit i2s    = (sf == 3'd3);
        bit leftj  = (sf == 3'd2) || i2s;
        int n      = (sf == 3'd0) ? 16 : (sf == 3'd1) ? 20 : 24;
        int total  = 4 + nf * 2 * h + 4;
        int s, p;
        logic [23:0] v;
        if (leftj && n > h) n = h;
        for (int t = 0; t < total; t++) begin
            bit_arr[t] = 3'b111;
            ws_arr[t]  = (t < 4) ? idle_level(sf) : ~idle_level(sf);
        end
        for (int fr = 0; fr < nf; fr++) begin
            for (int ch = 0; ch < 2; ch++) begin
                s = 4 + (2 * fr + ch) * h;
                for (int k = 0; k < h; k++)
                    ws_arr[s + k] = i2s ? (ch == 1) : (ch == 0);
                for (int l = 0; l < NL; l++) begin
                    v = (ch == 1) ? rv[l] : lv[l];
                    for (int j = 0; j < n; j++) begin
                        p = i2s ? (s + 1 + j) : leftj ? (s + j) : (s + h - n + j);
                        bit_arr[p][l] = v[23 - j];
                    end
                end
            end
        end
        vcount = 0;
        for (int t = 0; t < total; t++) begin
            @(negedge bclk);
            lrclk = ws_arr[t];
            sdata = bit_arr[t];
        end
        repeat (2) @(negedge bclk);
    endtask

    task automatic expect_frames(input string req, input int n, input int nf);
        check_val(req, "left samples", left_data,
                  pack3(top_bits(lv[0], n), top_bits(lv[1], n), top_bits(lv[2], n)));
        check_val(req, "right samples", right_data,
                  pack3(top_bits(rv[0], n), top_bits(rv[1], n), top_bits(rv[2], n)));
        check_val("R7", "strobe count", 72'(vcount), 72'(nf));
        check_val("R10", "error flag", 72'(fmt_err), 72'(0));
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0; fmt_sel = 3'd4; lrclk = 1'b0; sdata = '0;
        vcount = 0;
        for (int t = 0; t < 80; t++) begin
            @(negedge bclk);
            lrclk = (t / 8) % 2;
            sdata = 3'(t * 5);
        end
        @(negedge bclk);
        check_val("R11", "left in reset", left_data, '0);
        check_val("R11", "right in reset", right_data, '0);
        check_val("R11", "strobe in reset", 72'(vcount), 72'(0));
    endtask

    task automatic t_rj16_long;   // R3 R6 R2 R9
        set_vals(24'h812345, 24'h7F00AA, 24'hC3C3C3, 24'h1234FF, 24'hFFFF00, 24'h00FF55);
        do_reset(3'd0, idle_level(3'd0));
        play(3'd0, 32, 3);
        expect_frames("R3", 16, 3);
    endtask

    task automatic t_rj20_long;   // R3 R9
        set_vals(24'hABCDE0, 24'h135790, 24'h800010, 24'h0FEDC0, 24'h7654A0, 24'hFFFFF0);
        do_reset(3'd1, idle_level(3'd1));
        play(3'd1, 32, 2);
        expect_frames("R3", 20, 2);
    endtask

    task automatic t_rj24_long;   // R3 R2
        set_vals(24'h800001, 24'h000001, 24'h5A5A5A, 24'hFFFFFF, 24'h7FFFFE, 24'hA5A5A5);
        do_reset(3'd4, idle_level(3'd4));
        play(3'd4, 32, 3);
        expect_frames("R3", 24, 3);
    endtask

    task automatic t_rj16_short;  // R8
        set_vals(24'hBEEF00, 24'h800000, 24'h0001AB, 24'h7FFF00, 24'h123400, 24'hFEDC00);
        do_reset(3'd0, idle_level(3'd0));
        play(3'd0, 16, 3);
        expect_frames("R8", 16, 3);
    endtask

    task automatic t_lj24_long;   // R4 R6
        set_vals(24'h9ABCDE, 24'h2468AC, 24'hF0F0F0, 24'h0F0F0F, 24'hC00003, 24'h3FFFFC);
        do_reset(3'd2, idle_level(3'd2));
        play(3'd2, 32, 3);
        expect_frames("R4", 24, 3);
    endtask

    task automatic t_i2s_long;    // R5
        set_vals(24'hD00D11, 24'h456789, 24'h800000, 24'h7FFFFF, 24'hCAFE01, 24'h010203);
        do_reset(3'd3, idle_level(3'd3));
        play(3'd3, 32, 3);
        expect_frames("R5", 24, 3);
    endtask

    task automatic t_i2s_short;   // R8 R5
        set_vals(24'hA1B2C3, 24'h8F8F8F, 24'h123456, 24'hFEDCBA, 24'h00FFFF, 24'h7E7E7E);
        do_reset(3'd3, idle_level(3'd3));
        play(3'd3, 16, 3);
        expect_frames("R8", 16, 3);
    endtask

    task automatic t_reserved;    // R10
        set_vals(24'h111111, 24'h222222, 24'h333333, 24'h444444, 24'h555555, 24'h666666);
        do_reset(3'd6, idle_level(3'd4));
        play(3'd4, 32, 2);
        check_val("R10", "error flag", 72'(fmt_err), 72'(1));
        check_val("R10", "left zero", left_data, '0);
        check_val("R10", "right zero", right_data, '0);
        check_val("R10", "strobe count", 72'(vcount), 72'(2));
    endtask

    task automatic t_fmt_locked;  // R1
        set_vals(24'h0ACE01, 24'hFACE02, 24'h5EED03, 24'hBEAD04, 24'h0DD005, 24'h9E9E06);
        do_reset(3'd4, idle_level(3'd4));
        @(negedge bclk);
        fmt_sel = 3'd2;
        play(3'd4, 32, 2);
        check_val("R1", "left after pin change", left_data,
                  pack3(lv[0], lv[1], lv[2]));
        check_val("R1", "right after pin change", right_data,
                  pack3(rv[0], rv[1], rv[2]));
    endtask

    initial begin
        t_reset_state();
        t_rj16_long();
        t_rj20_long();
        t_rj24_long();
        t_rj16_short();
        t_lj24_long();
        t_i2s_long();
        t_i2s_short();
        t_reserved();
        t_fmt_locked();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule